// File: doc/BRIEF.md
# Immediate-Subtract Accumulator Execution Unit

This block is an 8-bit execution unit that runs one instruction: subtract an immediate byte from the accumulator. It reads the program from a byte-wide memory through a registered address bus and a read strobe. Each instruction starts with an opcode fetch cycle of four clock states. When the fetched opcode is D6h, a three-state operand read cycle follows, and the byte after the opcode is read as the immediate value.

The result is formed as the accumulator plus the two's complement of the immediate, truncated to eight bits, and it replaces the accumulator. Five status flags are written at the same moment as the accumulator: sign, zero, auxiliary carry, parity and carry. The carry flag reports a borrow, not the raw adder carry. Any other opcode acts as a one-byte no-operation that uses only the fetch cycle. The unit runs freely from reset and steps through the program one instruction after another.

Top module: `subimm_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `acc_out`, `flags_out`, `mem_rd`, `pc_out` and `mem_addr` (the last two take RESET_PC, default 0000h). After release it begins an opcode fetch at that address.
- R2: After opcode D6h and an immediate byte d, the accumulator becomes (A - d) mod 256, computed as A + (~d + 1).
- R3: Carry, `flags_out[0]`, is 1 when A < d (a borrow) and 0 otherwise.
- R4: Auxiliary carry, `flags_out[2]`, is the carry out of bit 3 of A[3:0] + (~d)[3:0] + 1.
- R5: Sign, `flags_out[4]`, equals bit 7 of the result. Zero, `flags_out[3]`, is 1 when the result is 00h. Parity, `flags_out[1]`, is 1 when the result has an even number of 1 bits.
- R6: A subtract instruction takes exactly 7 clock cycles: 4 for the opcode fetch and 3 for the operand read. The next opcode fetch starts in the 8th cycle.
- R7: `mem_addr` holds the opcode address for the whole fetch cycle and the operand address for the whole read cycle. `mem_rd` is high only in fetch states 2 and 3 and in read state 2.
- R8: `pc_out` increases by one after each byte is read. It ends two past the opcode address for a subtract and one past it for any other opcode.
- R9: An opcode other than D6h uses only the 4-state fetch cycle and leaves `acc_out` and `flags_out` unchanged.
- R10: `acc_out` and `flags_out` change only at the edge that ends the last state of the operand read cycle. During every earlier state of the instruction they hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Byte read from program memory at `mem_addr` |
| mem_addr | output | 16 | Registered memory address |
| mem_rd | output | 1 | Registered read strobe |
| pc_out | output | 16 | Program counter |
| acc_out | output | 8 | Accumulator |
| flags_out | output | 5 | {S, Z, AC, P, CY} |

## Verification
The bench targets the edge operands: equal values (zero result with no borrow), zero minus one (borrow with an all-ones result), and immediates whose low nibble is larger than the accumulator's. A design that took the carry straight from the adder shows CY inverted on every case. A design that derived AC from the borrow instead of the raw nibble carry shows AC wrong on the nibble cases. Non-D6h opcodes are mixed in, which catches a decoder that starts an operand read anyway: the program counter then skips a byte and the accumulator changes. The bench also samples the accumulator one state before write-back, which catches an update made one cycle early.

// File: rtl/subimm_pkg.sv
package subimm_pkg;

  typedef enum logic [2:0] {
    ST_F1 = 3'd0,
    ST_F2 = 3'd1,
    ST_F3 = 3'd2,
    ST_F4 = 3'd3,
    ST_R1 = 3'd4,
    ST_R2 = 3'd5,
    ST_R3 = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_t;

endpackage

// File: rtl/subimm_alu.sv
module subimm_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] res_o,
  output subimm_pkg::flag_t flg_o
);
  localparam int NIB_W = 4;

  logic [DATA_W-1:0] d_inv;
  logic [DATA_W:0]   sum_w;
  logic [NIB_W:0]    nib_sum;

  always_comb begin
    d_inv   = ~d_i;
    sum_w   = {1'b0, a_i} + {1'b0, d_inv} + {{DATA_W{1'b0}}, 1'b1};
    nib_sum = {1'b0, a_i[NIB_W-1:0]} + {1'b0, d_inv[NIB_W-1:0]} + {{NIB_W{1'b0}}, 1'b1};
    res_o   = sum_w[DATA_W-1:0];
    flg_o.s  = sum_w[DATA_W-1];
    flg_o.z  = (sum_w[DATA_W-1:0] == '0);
    flg_o.ac = nib_sum[NIB_W];
    flg_o.p  = ~^sum_w[DATA_W-1:0];
    flg_o.cy = ~sum_w[DATA_W];
  end
endmodule

// File: rtl/subimm_seq.sv
module subimm_seq #(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   is_sub_i,
  output subimm_pkg::seq_state_e st_o,
  output logic [ADDR_W-1:0]      pc_o,
  output logic [ADDR_W-1:0]      addr_o,
  output logic                   rd_o
);
  import subimm_pkg::*;

  localparam logic [ADDR_W-1:0] PC0 = RESET_PC[ADDR_W-1:0];

  seq_state_e st_q, st_d;
  logic [ADDR_W-1:0] pc_q, addr_q;
  logic rd_q;

  always_comb begin
    case (st_q)
      ST_F1:   st_d = ST_F2;
      ST_F2:   st_d = ST_F3;
      ST_F3:   st_d = ST_F4;
      ST_F4:   st_d = is_sub_i ? ST_R1 : ST_F1;
      ST_R1:   st_d = ST_R2;
      ST_R2:   st_d = ST_R3;
      default: st_d = ST_F1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_F1;
      pc_q   <= PC0;
      addr_q <= PC0;
      rd_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_F3 || st_q == ST_R2) pc_q <= pc_q + 1'b1;
      if (st_q == ST_F4 || st_q == ST_R3) addr_q <= pc_q;
      rd_q <= (st_d == ST_F2) || (st_d == ST_F3) || (st_d == ST_R2);
    end
  end

  assign st_o   = st_q;
  assign pc_o   = pc_q;
  assign addr_o = addr_q;
  assign rd_o   = rd_q;
endmodule

// File: rtl/subimm_exec_unit.sv
module subimm_exec_unit #(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [7:0]  SUB_OPC  = 8'hD6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] pc_out,
  output logic [DATA_W-1:0] acc_out,
  output logic [4:0]        flags_out
);
  import subimm_pkg::*;

  localparam logic [DATA_W-1:0] OPC = SUB_OPC[DATA_W-1:0];

  seq_state_e        st;
  logic [DATA_W-1:0] opc_q, opnd_q, acc_q, alu_res;
  flag_t             flg_q, alu_flg;
  logic              is_sub;

  assign is_sub = (opc_q == OPC);

  subimm_seq #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .is_sub_i (is_sub),
    .st_o     (st),
    .pc_o     (pc_out),
    .addr_o   (mem_addr),
    .rd_o     (mem_rd)
  );

  subimm_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i   (acc_q),
    .d_i   (opnd_q),
    .res_o (alu_res),
    .flg_o (alu_flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q  <= '0;
      opnd_q <= '0;
      acc_q  <= '0;
      flg_q  <= '0;
    end else begin
      if (st == ST_F3) opc_q  <= mem_rdata;
      if (st == ST_R2) opnd_q <= mem_rdata;
      if (st == ST_R3) begin
        acc_q <= alu_res;
        flg_q <= alu_flg;
      end
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = flg_q;
endmodule

// File: rtl/subimm_exec_chk.sv
module subimm_exec_chk #(
  parameter int         DATA_W  = 8,
  parameter int         ADDR_W  = 16,
  parameter logic [7:0] SUB_OPC = 8'hD6
) (
  input logic                   clk,
  input logic                   rst,
  input subimm_pkg::seq_state_e st,
  input logic [DATA_W-1:0]      opc_q,
  input logic [DATA_W-1:0]      acc_out,
  input logic [4:0]             flags_out,
  input logic [ADDR_W-1:0]      pc_out,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic                   mem_rd
);
  import subimm_pkg::*;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && flags_out == '0 && !mem_rd && st == ST_F1));

  a_r10_update_at_end: assert property (@(posedge clk) disable iff (rst)
    (!$stable(acc_out) || !$stable(flags_out)) |-> $past(st) == ST_R3);

  a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> pc_out == $past(pc_out) + 1'b1);

  a_r7_rd_window: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (st == ST_F2 || st == ST_F3 || st == ST_R2));

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (st != ST_F1 && st != ST_R1) |-> $stable(mem_addr));

  a_r9_nop_short: assert property (@(posedge clk) disable iff (rst)
    (st == ST_F4 && opc_q != SUB_OPC[DATA_W-1:0]) |=> (st == ST_F1 && $stable(acc_out)));

  a_r6_read_ends: assert property (@(posedge clk) disable iff (rst)
    st == ST_R3 |=> st == ST_F1);
endmodule

bind subimm_exec_unit subimm_exec_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUB_OPC(SUB_OPC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st        (st),
  .opc_q     (opc_q),
  .acc_out   (acc_out),
  .flags_out (flags_out),
  .pc_out    (pc_out),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd)
);

// File: tb/subimm_exec_unit_tb.sv
`timescale 1ns/1ps
module subimm_exec_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, pc_out;
  logic        mem_rd;
  logic [7:0]  acc_out;
  logic [4:0]  flags_out;

  logic [7:0]  prog [0:1023];
  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0]  m_acc = 8'h00;
  logic [4:0]  m_flg = 5'h00;
  logic [15:0] ptr = 16'h0000;

  always #4 clk = ~clk;

  assign mem_rdata = prog[mem_addr[9:0]];

  subimm_exec_unit u_dut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .pc_out(pc_out), .acc_out(acc_out), .flags_out(flags_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [12:0] ref_sub(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    logic [4:0] nib;
    int ones;
    r = a - d;
    nib = {1'b0, a[3:0]} + {1'b0, ~d[3:0]} + 5'd1;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    // {S,Z,AC,P,CY}, result
    return {r[7], (r == 8'h00), nib[4], (ones % 2 == 0), (a < d), r};
  endfunction

  task automatic do_sub(input logic [7:0] d);
    logic [12:0] e;
    e = ref_sub(m_acc, d);
    prog[ptr[9:0]]      = 8'hD6;
    prog[ptr[9:0] + 1]  = d;
    chk("R7 fetch addr", mem_addr, ptr);
    step(1); chk("R7 rd in fetch", {15'd0, mem_rd}, 16'd1);
    step(2); chk("R8 pc after opcode", pc_out, ptr + 16'd1);
    chk("R7 rd low F4", {15'd0, mem_rd}, 16'd0);
    step(1); chk("R7 operand addr", mem_addr, ptr + 16'd1);
    step(2); chk("R10 acc held", {8'd0, acc_out}, {8'd0, m_acc});
    chk("R10 flags held", {11'd0, flags_out}, {11'd0, m_flg});
    chk("R8 pc after operand", pc_out, ptr + 16'd2);
    step(1);
    chk("R2 result", {8'd0, acc_out}, {8'd0, e[7:0]});
    chk("R3 carry/borrow", {15'd0, flags_out[0]}, {15'd0, e[8]});
    chk("R4 aux carry", {15'd0, flags_out[2]}, {15'd0, e[10]});
    chk("R5 sign/zero/parity", {13'd0, flags_out[4], flags_out[3], flags_out[1]},
        {13'd0, e[12], e[11], e[9]});
    chk("R6 next fetch addr", mem_addr, ptr + 16'd2);
    m_acc = e[7:0];
    m_flg = e[12:8];
    ptr   = ptr + 16'd2;
  endtask

  task automatic do_nop(input logic [7:0] op);
    prog[ptr[9:0]] = op;
    step(4);
    chk("R9 acc unchanged", {8'd0, acc_out}, {8'd0, m_acc});
    chk("R9 flags unchanged", {11'd0, flags_out}, {11'd0, m_flg});
    chk("R8 pc after nop", pc_out, ptr + 16'd1);
    chk("R9 next fetch addr", mem_addr, ptr + 16'd1);
    ptr = ptr + 16'd1;
  endtask

  task automatic pair(input logic [7:0] a, input logic [7:0] d);
    do_sub(m_acc - a);
    do_sub(d);
  endtask

  initial begin
    int seed;
    for (int i = 0; i < 1024; i++) prog[i] = 8'h00;
    seed = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 acc reset", {8'd0, acc_out}, 16'd0);
    chk("R1 flags reset", {11'd0, flags_out}, 16'd0);
    chk("R1 pc reset", pc_out, 16'd0);
    chk("R1 addr reset", mem_addr, 16'd0);
    chk("R1 rd reset", {15'd0, mem_rd}, 16'd0);
    pair(8'hCD, 8'hAB);
    pair(8'hAB, 8'hCD);
    pair(8'h00, 8'h00);
    pair(8'h00, 8'h01);
    pair(8'h80, 8'h01);
    pair(8'hFF, 8'hFF);
    pair(8'h10, 8'h01);
    pair(8'h3C, 8'h0F);
    do_nop(8'h00);
    do_nop(8'hD7);
    do_nop(8'hFF);
    for (int k = 0; k < 100; k++) begin
      pair(8'($urandom), 8'($urandom));
      if (k % 10 == 0) do_nop(8'h55);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule